// File: doc/BRIEF.md
# Layer-Mask Hough Accumulator for Track Finding

This block finds straight-line candidates in the parameter space of charged-particle tracks for one slice of a detector region. Each hit arrives as an azimuth, a precomputed reciprocal radius and a layer number. The hit stands for a line in a two-dimensional grid. One axis is the starting azimuth `phi0` and the other is the curvature term. For every `phi0` column the block evaluates the curvature at the column centre, one column per clock. It then sets that hit's layer bit in the matching cell.

Each cell holds a bitmask of the layers that crossed it rather than a vote count. Many hits on one layer therefore weigh no more than a single hit. When the event is over, a pulse on `event_end` starts a scan of every cell. Each cell whose count of distinct layers reaches `cand_thr` is sent out as a candidate on a valid/ready stream. A one-cycle `scan_done` pulse follows the last cell, and then a clear pass empties the grid for the next event.

Hits enter on a valid/ready handshake. `hit_ready` is high only while the block is idle with no end of event pending. Candidates leave on a valid/ready handshake, and the consumer may hold `cand_ready` low for as long as it likes. While it does, the offered candidate stays unchanged and the scan waits.

Top module: `hough_accum`

## Requirements
- R1: After reset `hit_ready` is 1, `cand_valid` and `scan_done` are 0, and every cell holds an empty mask.
- R2: A hit is taken on a clock edge where `hit_valid` and `hit_ready` are both 1. `hit_ready` is then 0 for exactly NUM_PHI cycles, one per `phi0` column.
- R3: For column k the centre is c = PHI0_MIN + k*PHI0_STEP + PHI0_STEP/2. The curvature bin is ((c - phi) * inv_r) arithmetically shifted right by FRAC_SHIFT, plus NUM_CURV/2, where `phi` is signed and `inv_r` is unsigned. The hit sets bit `hit_layer` of the mask in cell (k, bin).
- R4: A column whose computed bin is below 0 or at least NUM_CURV changes no cell.
- R5: A mask bit is set by OR, so repeated hits on one layer count as one layer.
- R6: A cell is a candidate when the number of ones in its mask is at least `cand_thr`. Threshold 0 makes every cell a candidate.
- R7: The scan visits cells with `phi0` as the outer index and curvature as the inner index, both rising from 0. Each candidate reports its `cand_phi0_bin`, `cand_curv_bin` and `cand_mask`, and non-candidate cells are passed over at one per cycle.
- R8: While `cand_valid` is 1 and `cand_ready` is 0, the candidate fields and `cand_valid` hold their values.
- R9: `scan_done` is a one-cycle pulse in the cycle after the last cell leaves the scan. With `cand_ready` held at 1 it comes NUM_PHI*NUM_CURV cycles after the edge that samples `event_end`.
- R10: After `scan_done` a clear pass of NUM_PHI cycles runs with `hit_ready` at 0. The next event then starts from an empty grid.
- R11: `event_end` sampled while a hit is being processed, or on the edge that takes a hit, is remembered. The scan starts once that hit is complete and includes it. `event_end` during the scan or the clear pass is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Hit offered |
| hit_ready | output | 1 | Hit can be taken |
| hit_phi | input | COORD_W | Hit azimuth, signed |
| hit_inv_r | input | COORD_W | Reciprocal radius, unsigned fixed point |
| hit_layer | input | clog2(NLAYER) | Layer index of the hit |
| event_end | input | 1 | Pulse: event complete, start scan |
| cand_thr | input | clog2(NLAYER+1) | Minimum distinct layers for a candidate |
| cand_valid | output | 1 | Candidate offered |
| cand_ready | input | 1 | Consumer takes candidate |
| cand_phi0_bin | output | clog2(NUM_PHI) | Candidate phi0 column |
| cand_curv_bin | output | clog2(NUM_CURV) | Candidate curvature bin |
| cand_mask | output | NLAYER | Layers present in the candidate cell |
| scan_done | output | 1 | One-cycle pulse after the scan |

## Verification
Each hit keeps `hit_ready` low for NUM_PHI cycles after its accepting edge. The bench counts the sampling windows between the handshake and the return of `hit_ready`. Results become visible only when the scan runs, so each scan is compared cell by cell against a grid the bench builds from the line equation. With `cand_ready` held high, `scan_done` is due NUM_PHI*NUM_CURV edges after the edge that samples `event_end`, and `hit_ready` comes back NUM_PHI edges after that. The bench counts falling-edge windows from the sampling edge to check both. Under random back-pressure it checks only the order and content of the candidates, not their timing.

// File: rtl/hough_pkg.sv
package hough_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_SCAN,
    ST_CLEAR
  } acc_state_t;
endpackage

// File: rtl/hough_curv_bin.sv
// Maps one hit and one phi0 column onto a curvature bin.
module hough_curv_bin #(
  parameter int COORD_W    = 16,
  parameter int NUM_PHI    = 16,
  parameter int NUM_CURV   = 32,
  parameter int PHI0_MIN   = -512,
  parameter int PHI0_STEP  = 64,
  parameter int FRAC_SHIFT = 14,
  localparam int KW = $clog2(NUM_PHI),
  localparam int CB_W = $clog2(NUM_CURV)
) (
  input  logic [KW-1:0]      col,
  input  logic [COORD_W-1:0] phi,
  input  logic [COORD_W-1:0] inv_r,
  output logic [CB_W-1:0]    bin,
  output logic               in_range
);
  localparam int PW = 2 * COORD_W + 16;

  logic signed [PW-1:0] centre, diff, inv_ext, prod, idx;

  always_comb begin
    centre   = PW'(PHI0_MIN) + PW'(PHI0_STEP) * $signed(PW'(col)) + PW'(PHI0_STEP / 2);
    diff     = centre - PW'($signed(phi));
    inv_ext  = $signed(PW'(inv_r));
    prod     = diff * inv_ext;
    idx      = (prod >>> FRAC_SHIFT) + PW'(NUM_CURV / 2);
    in_range = !idx[PW-1] && (idx < PW'(NUM_CURV));
    bin      = idx[CB_W-1:0];
  end
endmodule

// File: rtl/hough_layer_count.sv
// Counts the distinct layers present in one cell mask.
module hough_layer_count #(
  parameter int NLAYER = 8,
  localparam int CNT_W = $clog2(NLAYER + 1)
) (
  input  logic [NLAYER-1:0] mask,
  output logic [CNT_W-1:0]  count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < NLAYER; i++) count = count + CNT_W'(mask[i]);
  end
endmodule

// File: rtl/hough_accum.sv
module hough_accum
  import hough_pkg::*;
#(
  parameter int COORD_W    = 16,
  parameter int NUM_PHI    = 16,
  parameter int NUM_CURV   = 32,
  parameter int NLAYER     = 8,
  parameter int PHI0_MIN   = -512,
  parameter int PHI0_STEP  = 64,
  parameter int FRAC_SHIFT = 14,
  localparam int KW    = $clog2(NUM_PHI),
  localparam int CB_W  = $clog2(NUM_CURV),
  localparam int LW    = $clog2(NLAYER),
  localparam int CNT_W = $clog2(NLAYER + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_valid,
  output logic               hit_ready,
  input  logic [COORD_W-1:0] hit_phi,
  input  logic [COORD_W-1:0] hit_inv_r,
  input  logic [LW-1:0]      hit_layer,
  input  logic               event_end,
  input  logic [CNT_W-1:0]   cand_thr,
  output logic               cand_valid,
  input  logic               cand_ready,
  output logic [KW-1:0]      cand_phi0_bin,
  output logic [CB_W-1:0]    cand_curv_bin,
  output logic [NLAYER-1:0]  cand_mask,
  output logic               scan_done
);
  acc_state_t         state_q;
  logic [KW-1:0]      col_q;
  logic [KW-1:0]      sc_phi_q;
  logic [CB_W-1:0]    sc_curv_q;
  logic [COORD_W-1:0] h_phi_q, h_invr_q;
  logic [LW-1:0]      h_layer_q;
  logic               pend_q, done_q;
  logic [NLAYER-1:0]  grid [NUM_PHI][NUM_CURV];

  logic [CB_W-1:0]    fill_bin;
  logic               fill_ok;
  logic [NLAYER-1:0]  rd_mask;
  logic [CNT_W-1:0]   rd_cnt;
  logic               advance, col_last, scan_last;

  hough_curv_bin #(
    .COORD_W(COORD_W), .NUM_PHI(NUM_PHI), .NUM_CURV(NUM_CURV),
    .PHI0_MIN(PHI0_MIN), .PHI0_STEP(PHI0_STEP), .FRAC_SHIFT(FRAC_SHIFT)
  ) u_bin (
    .col(col_q), .phi(h_phi_q), .inv_r(h_invr_q),
    .bin(fill_bin), .in_range(fill_ok)
  );

  assign rd_mask = grid[sc_phi_q][sc_curv_q];

  hough_layer_count #(.NLAYER(NLAYER)) u_cnt (.mask(rd_mask), .count(rd_cnt));

  assign hit_ready     = (state_q == ST_IDLE) && !pend_q;
  assign cand_valid    = (state_q == ST_SCAN) && (rd_cnt >= cand_thr);
  assign cand_phi0_bin = sc_phi_q;
  assign cand_curv_bin = sc_curv_q;
  assign cand_mask     = rd_mask;
  assign scan_done     = done_q;

  assign advance   = (state_q == ST_SCAN) && (!cand_valid || cand_ready);
  assign col_last  = (col_q == KW'(NUM_PHI - 1));
  assign scan_last = (sc_phi_q == KW'(NUM_PHI - 1)) && (sc_curv_q == CB_W'(NUM_CURV - 1));

  // Control sequence: idle -> fill (one column per cycle) -> scan -> clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      col_q     <= '0;
      sc_phi_q  <= '0;
      sc_curv_q <= '0;
      h_phi_q   <= '0;
      h_invr_q  <= '0;
      h_layer_q <= '0;
      pend_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (hit_valid && hit_ready) begin
            h_phi_q   <= hit_phi;
            h_invr_q  <= hit_inv_r;
            h_layer_q <= hit_layer;
            col_q     <= '0;
            pend_q    <= event_end;
            state_q   <= ST_FILL;
          end else if (pend_q || event_end) begin
            pend_q    <= 1'b0;
            sc_phi_q  <= '0;
            sc_curv_q <= '0;
            state_q   <= ST_SCAN;
          end
        end
        ST_FILL: begin
          if (event_end) pend_q <= 1'b1;
          if (col_last) begin
            col_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        ST_SCAN: begin
          if (advance) begin
            if (scan_last) begin
              done_q  <= 1'b1;
              col_q   <= '0;
              state_q <= ST_CLEAR;
            end else if (sc_curv_q == CB_W'(NUM_CURV - 1)) begin
              sc_curv_q <= '0;
              sc_phi_q  <= sc_phi_q + 1'b1;
            end else begin
              sc_curv_q <= sc_curv_q + 1'b1;
            end
          end
        end
        ST_CLEAR: begin
          if (col_last) begin
            col_q   <= '0;
            state_q <= ST_IDLE;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Accumulator grid: OR in a layer bit during fill, wipe a column per clear cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PHI; p++)
        for (int c = 0; c < NUM_CURV; c++) grid[p][c] <= '0;
    end else if (state_q == ST_FILL && fill_ok) begin
      grid[col_q][fill_bin][h_layer_q] <= 1'b1;
    end else if (state_q == ST_CLEAR) begin
      for (int c = 0; c < NUM_CURV; c++) grid[col_q][c] <= '0;
    end
  end
endmodule

// File: rtl/hough_accum_chk.sv
module hough_accum_chk #(
  parameter int NUM_PHI  = 16,
  parameter int NUM_CURV = 32,
  parameter int NLAYER   = 8,
  localparam int KW    = $clog2(NUM_PHI),
  localparam int CB_W  = $clog2(NUM_CURV),
  localparam int CNT_W = $clog2(NLAYER + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hit_valid,
  input logic              hit_ready,
  input logic [CNT_W-1:0]  cand_thr,
  input logic              cand_valid,
  input logic              cand_ready,
  input logic [KW-1:0]     cand_phi0_bin,
  input logic [CB_W-1:0]   cand_curv_bin,
  input logic [NLAYER-1:0] cand_mask,
  input logic              scan_done
);
  assert_hit_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && hit_ready |=> !hit_ready);

  assert_cand_thresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> ($countones(cand_mask) >= int'(cand_thr)));

  assert_scan_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> !hit_ready);

  assert_cand_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !cand_ready |=> cand_valid && $stable(cand_phi0_bin)
      && $stable(cand_curv_bin) && $stable(cand_mask));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !cand_valid && !hit_ready);

  assert_clear_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !hit_ready);
endmodule

bind hough_accum hough_accum_chk #(
  .NUM_PHI(NUM_PHI), .NUM_CURV(NUM_CURV), .NLAYER(NLAYER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ready(hit_ready),
  .cand_thr(cand_thr), .cand_valid(cand_valid), .cand_ready(cand_ready),
  .cand_phi0_bin(cand_phi0_bin), .cand_curv_bin(cand_curv_bin),
  .cand_mask(cand_mask), .scan_done(scan_done)
);

// File: tb/sim_hough_accum.sv
`timescale 1ns/1ps
module sim_hough_accum;
  localparam int COORD_W = 16, NUM_PHI = 16, NUM_CURV = 32, NLAYER = 8;
  localparam int PHI0_MIN = -512, PHI0_STEP = 64, FRAC_SHIFT = 14;
  localparam int NCELL = NUM_PHI * NUM_CURV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hit_valid = 1'b0, event_end = 1'b0, cand_ready = 1'b0;
  logic [15:0] hit_phi = '0, hit_inv_r = '0;
  logic [2:0] hit_layer = '0;
  logic [3:0] cand_thr = 4'd6;
  logic hit_ready, cand_valid, scan_done;
  logic [3:0] cand_phi0_bin;
  logic [4:0] cand_curv_bin;
  logic [7:0] cand_mask;

  int n_chk = 0, n_fail = 0;
  logic [15:0] lf = 16'hACE1;
  logic [7:0] mdl [NUM_PHI][NUM_CURV];

  always #2 clk = ~clk;

  hough_accum #(
    .COORD_W(COORD_W), .NUM_PHI(NUM_PHI), .NUM_CURV(NUM_CURV), .NLAYER(NLAYER),
    .PHI0_MIN(PHI0_MIN), .PHI0_STEP(PHI0_STEP), .FRAC_SHIFT(FRAC_SHIFT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ready(hit_ready),
    .hit_phi(hit_phi), .hit_inv_r(hit_inv_r), .hit_layer(hit_layer),
    .event_end(event_end), .cand_thr(cand_thr), .cand_valid(cand_valid),
    .cand_ready(cand_ready), .cand_phi0_bin(cand_phi0_bin),
    .cand_curv_bin(cand_curv_bin), .cand_mask(cand_mask), .scan_done(scan_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void step_lf();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endfunction

  // Line equation from R3; returns -1 when the column is skipped (R4)
  function automatic int exp_bin(int k, int phi, int invr);
    longint centre, prod, v;
    centre = longint'(PHI0_MIN + k * PHI0_STEP + PHI0_STEP / 2);
    prod   = (centre - longint'(phi)) * longint'(invr);
    v      = (prod >>> FRAC_SHIFT) + NUM_CURV / 2;
    if (v < 0 || v >= NUM_CURV) return -1;
    return int'(v);
  endfunction

  task automatic clear_model();
    for (int p = 0; p < NUM_PHI; p++)
      for (int c = 0; c < NUM_CURV; c++) mdl[p][c] = '0;
  endtask

  // end_same: event_end on the accepting edge; end_fill: event_end during fill
  task automatic send_hit(input int phi, input int invr, input int layer,
                          input bit end_same, input bit end_fill);
    int cnt;
    for (int k = 0; k < NUM_PHI; k++) begin
      int b = exp_bin(k, phi, invr);
      if (b >= 0) mdl[k][b][layer] = 1'b1;
    end
    @(negedge clk);
    hit_valid = 1'b1; hit_phi = 16'(phi); hit_inv_r = 16'(invr);
    hit_layer = 3'(layer); event_end = end_same;
    #1;
    while (!hit_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    hit_valid = 1'b0;
    event_end = end_fill;
    if (!end_same && !end_fill) begin
      #1; cnt = 0;
      while (!hit_ready && cnt < 100) begin cnt++; @(negedge clk); #1; end
      chk(cnt == NUM_PHI, "R2", "hit_ready low cycles after a hit", cnt, NUM_PHI);
    end else begin
      @(negedge clk);
      event_end = 1'b0;
    end
  endtask

  task automatic run_event(input int thr, input bit bp, input bit pulse);
    int n, sp, cnt;
    cand_thr = 4'(thr);
    if (pulse) begin
      @(negedge clk); event_end = 1'b1;
      @(negedge clk); event_end = 1'b0;
    end else begin
      @(negedge clk);
    end
    n = 0; sp = 0;
    forever begin
      step_lf();
      cand_ready = bp ? lf[0] : 1'b1;
      #1;
      if (scan_done || n > 20000) break;
      if (cand_valid && cand_ready) begin
        while (sp < NCELL && $countones(mdl[sp / NUM_CURV][sp % NUM_CURV]) < thr) sp++;
        if (sp >= NCELL) begin
          chk(1'b0, "R6", "unexpected extra candidate at cell",
              {cand_phi0_bin, cand_curv_bin}, -1);
        end else begin
          chk(cand_phi0_bin == 4'(sp / NUM_CURV) && cand_curv_bin == 5'(sp % NUM_CURV)
              && cand_mask == mdl[sp / NUM_CURV][sp % NUM_CURV],
              "R3 R5 R7", "candidate {phi0,curv,mask}",
              {cand_phi0_bin, cand_curv_bin, cand_mask},
              {4'(sp / NUM_CURV), 5'(sp % NUM_CURV), mdl[sp / NUM_CURV][sp % NUM_CURV]});
          sp++;
        end
      end
      @(negedge clk);
      n++;
    end
    chk(scan_done == 1'b1, "R9", "scan_done reached", scan_done, 1);
    while (sp < NCELL && $countones(mdl[sp / NUM_CURV][sp % NUM_CURV]) < thr) sp++;
    chk(sp == NCELL, "R6 R7", "missing candidate at cell index", sp, NCELL);
    if (pulse && !bp)
      chk(n == NCELL, "R9", "cycles from event_end edge to scan_done", n, NCELL);
    chk(hit_ready == 1'b0, "R10", "hit_ready in scan_done cycle", hit_ready, 0);
    cnt = 0;
    while (!hit_ready && cnt < 100) begin @(negedge clk); #1; cnt++; end
    chk(cnt == NUM_PHI, "R10", "clear pass length", cnt, NUM_PHI);
    cand_ready = 1'b0;
    clear_model();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_model();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(hit_ready == 1'b1, "R1", "hit_ready after reset", hit_ready, 1);
    chk(cand_valid == 1'b0, "R1", "cand_valid after reset", cand_valid, 0);
    chk(scan_done == 1'b0, "R1", "scan_done after reset", scan_done, 0);

    // R1: grid empty after reset, every cell reported with an empty mask
    run_event(0, 1'b1, 1'b1);

    // Full track through column 5 centre, eight layers, no back-pressure (R3 R9)
    for (int l = 0; l < NLAYER; l++) send_hit(-160, 1000 + l * 2900, l, 1'b0, 1'b0);
    run_event(6, 1'b0, 1'b1);

    // R5: seven layers, layer 2 repeated; threshold 8 must not fire on repeats
    for (int l = 0; l < 7; l++) send_hit(-96, 700 + l * 1700, l, 1'b0, 1'b0);
    for (int r = 0; r < 3; r++) send_hit(-96, 5000 + r * 3000, 2, 1'b0, 1'b0);
    run_event(8, 1'b1, 1'b1);
    for (int l = 0; l < 7; l++) send_hit(-96, 700 + l * 1700, l, 1'b0, 1'b0);
    for (int r = 0; r < 3; r++) send_hit(-96, 5000 + r * 3000, 2, 1'b0, 1'b0);
    run_event(7, 1'b0, 1'b1);

    // R4: every column out of range, grid stays empty
    send_hit(-32768, 65535, 4, 1'b0, 1'b0);
    run_event(0, 1'b1, 1'b1);

    // Threshold sweep over pseudo-random hits with back-pressure (R6 R8)
    for (int t = 1; t <= 3; t++) begin
      for (int h = 0; h < 24; h++) begin
        step_lf();
        send_hit(int'(lf[9:0]) - 512, int'(lf[15:4]) & 16'h1FFF, int'(lf[2:0]), 1'b0, 1'b0);
      end
      run_event(t, 1'b1, 1'b1);
    end

    // R11: event_end on the accepting edge, then during fill
    for (int h = 0; h < 6; h++) send_hit(-300 + h * 40, 3000, h, 1'b0, 1'b0);
    send_hit(-100, 2000, 7, 1'b1, 1'b0);
    run_event(1, 1'b1, 1'b0);
    for (int h = 0; h < 6; h++) send_hit(200 - h * 30, 4000, h, 1'b0, 1'b0);
    send_hit(50, 6000, 6, 1'b0, 1'b1);
    run_event(1, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule